// File: doc/BRIEF.md
# Circular Receive-Buffer Address Generator

This block hands out destination addresses for incoming packet payloads. Software first registers a ring of persistent receive buffers. Each ring entry holds a 64-bit base address, a byte size and a flag that says whether the buffer lives in accelerator (GPU) memory or in host memory. For every packet that is presented with its payload length, the block returns the address at which the payload is to be written. It then moves a running write offset forward inside the current buffer.

A buffer closes in one of two ways. Either a packet fills it exactly, or a packet does not fit in the space that is left. When a buffer closes, the block raises a completion event that carries the entry index and the number of bytes used. The event is held until a consumer takes it. Work then continues at the start of the next entry, and after the last registered entry it returns to entry 0. For example, with buffers of eight equal payloads each, a run of 32 packets over four buffers gives exactly four events and returns to the first buffer.

Address translation and the DMA transfer itself are done downstream of this block.

Top module: `rxring_addr_gen`

## Requirements
- R1: After reset, `rsp_valid` and `evt_valid` are 0, `req_ready` is 1 and no ring is registered.
- R2: A cycle with `cfg_we` high writes base, size and memory flag into entry `cfg_idx`. If `cfg_last` is also high, the ring length becomes `cfg_idx`+1 and work restarts at entry 0, offset 0. `req_ready` is 0 in any cycle with `cfg_we` or `cfg_clear` high.
- R3: An accepted packet (`req_valid` and `req_ready` high at a clock edge) gets a response one cycle later. The response is `rsp_valid`=1 and `rsp_err`=0, with `rsp_addr` = base of the current entry + current offset, `rsp_idx` = current entry and `rsp_gpu` = that entry's memory flag. The offset then grows by `req_len`.
- R4: When an accepted packet brings the offset exactly to the entry size, a completion event follows one cycle later with `evt_idx` = that entry and `evt_bytes` = the size. The next packet goes to the following entry at offset 0.
- R5: Suppose the offset is above 0 and offset + `req_len` exceeds the entry size. Then `req_ready` is 0 in that cycle and the current entry is closed, with an event whose `evt_bytes` equals the old offset. The packet is then accepted at the base of the next entry.
- R6: The entry after the last registered entry is entry 0.
- R7: A request is accepted but answered with `rsp_err`=1, leaving the offset and the current entry unchanged, in three cases: no ring is registered, `req_len` is 0, or `req_len` is larger than the current entry size.
- R8: While `evt_valid`=1 and `evt_ready`=0, `evt_idx` and `evt_bytes` stay stable and `req_ready` is 0. An event is removed at a clock edge where `evt_ready` is 1.
- R9: A cycle with `cfg_clear` high deregisters the ring, so later requests are answered with `rsp_err`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write one ring entry |
| cfg_clear | input | 1 | Deregister the whole ring |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_base | input | ADDR_W | Buffer base address |
| cfg_size | input | SIZE_W | Buffer size in bytes |
| cfg_gpu | input | 1 | 1 = accelerator memory, 0 = host memory |
| cfg_last | input | 1 | This entry ends the ring and restarts it |
| req_valid | input | 1 | Packet address request |
| req_len | input | LEN_W | Payload length in bytes |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Request rejected |
| rsp_addr | output | ADDR_W | Destination address |
| rsp_gpu | output | 1 | Memory type of the destination |
| rsp_idx | output | IDX_W | Entry that receives the payload |
| evt_valid | output | 1 | Completion event pending |
| evt_ready | input | 1 | Consumer takes the event |
| evt_idx | output | IDX_W | Entry that was completed |
| evt_bytes | output | SIZE_W | Bytes used in that entry |

## Verification
A wrong offset shows up on `rsp_addr` in the very next response. After a buffer closes, it also shows up as a wrong `evt_bytes`. A wrong current-entry pointer, whether it skips an entry or wraps late, changes `rsp_idx` and the base part of the address within one response. A flaw in closing a buffer shows up as a missing or extra event, or as a `req_ready` value that differs from the one computed from the offset, size and held event in that same cycle. The bench follows every one of these quantities cycle by cycle, so an error surfaces within a cycle of its cause.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int ADDR_W = 64;
  localparam int SIZE_W = 32;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [SIZE_W-1:0] size;
    logic              gpu;
  } buf_ent_t;
endpackage

// File: rtl/rxr_table.sv
module rxr_table
  import rxr_pkg::*;
#(
  parameter int NUM_BUF = 16,
  localparam int IDX_W = $clog2(NUM_BUF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  buf_ent_t         wr_ent,
  input  logic [IDX_W-1:0] rd_idx,
  output buf_ent_t         rd_ent
);
  buf_ent_t ent_q [NUM_BUF];

  // one register per entry, each with its own write enable
  for (genvar g = 0; g < NUM_BUF; g++) begin : g_ent
    logic     ld;
    buf_ent_t ent_d;

    always_comb begin
      ld    = wr_en && (wr_idx == IDX_W'(g));
      ent_d = ld ? wr_ent : ent_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[g] <= '0;
      else        ent_q[g] <= ent_d;
    end
  end

  assign rd_ent = ent_q[rd_idx];
endmodule

// File: rtl/rxr_cursor.sv
module rxr_cursor
  import rxr_pkg::*;
#(
  parameter int NUM_BUF = 16,
  parameter int LEN_W   = 16,
  localparam int IDX_W = $clog2(NUM_BUF),
  localparam int CNT_W = $clog2(NUM_BUF + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_clear,
  input  logic              cfg_last,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              req_valid,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              evt_free,
  input  buf_ent_t          cur_ent,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [CNT_W-1:0]  ring_cnt,
  output logic              req_ready,
  output logic              acc,
  output logic              acc_err,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              close_fire,
  output logic [SIZE_W-1:0] close_bytes
);
  logic [SIZE_W-1:0] off_q, off_d;
  logic [IDX_W-1:0]  idx_q, idx_d, idx_nxt;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SIZE_W:0]   fill;
  logic [SIZE_W:0]   len_x;
  logic              run, bad, spill, fits, exact;

  always_comb begin
    len_x   = (SIZE_W+1)'(req_len);
    fill    = {1'b0, off_q} + len_x;
    idx_nxt = ((CNT_W'(idx_q) + CNT_W'(1)) == cnt_q) ? '0 : idx_q + IDX_W'(1);
    run     = rst_n && !cfg_we && !cfg_clear && evt_free;
    bad     = (cnt_q == '0) || (req_len == '0) || (len_x > {1'b0, cur_ent.size});
    spill   = !bad && (fill > {1'b0, cur_ent.size});
    fits    = !bad && !spill;
    exact   = fits && (fill == {1'b0, cur_ent.size});

    req_ready   = run && !spill;
    acc         = req_valid && req_ready;
    acc_err     = bad;
    acc_addr    = cur_ent.base + ADDR_W'(off_q);
    close_fire  = req_valid && run && (spill || exact);
    close_bytes = spill ? off_q : cur_ent.size;
  end

  // next-state selection, configuration first
  always_comb begin
    off_d = off_q;
    idx_d = idx_q;
    cnt_d = cnt_q;
    if (cfg_clear) begin
      cnt_d = '0;
      idx_d = '0;
      off_d = '0;
    end else if (cfg_we && cfg_last) begin
      cnt_d = CNT_W'(cfg_idx) + CNT_W'(1);
      idx_d = '0;
      off_d = '0;
    end else if (close_fire) begin
      idx_d = idx_nxt;
      off_d = '0;
    end else if (acc && fits) begin
      off_d = fill[SIZE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      idx_q <= '0;
      cnt_q <= '0;
    end else begin
      off_q <= off_d;
      idx_q <= idx_d;
      cnt_q <= cnt_d;
    end
  end

  assign cur_idx  = idx_q;
  assign ring_cnt = cnt_q;
endmodule

// File: rtl/rxr_evt.sv
module rxr_evt
  import rxr_pkg::*;
#(
  parameter int NUM_BUF = 16,
  localparam int IDX_W = $clog2(NUM_BUF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [IDX_W-1:0]  fire_idx,
  input  logic [SIZE_W-1:0] fire_bytes,
  input  logic              evt_ready,
  output logic              evt_free,
  output logic              evt_valid,
  output logic [IDX_W-1:0]  evt_idx,
  output logic [SIZE_W-1:0] evt_bytes
);
  logic              v_q, v_d;
  logic [IDX_W-1:0]  i_q, i_d;
  logic [SIZE_W-1:0] b_q, b_d;

  always_comb begin
    evt_free = !v_q || evt_ready;
    v_d = v_q;
    i_d = i_q;
    b_d = b_q;
    if (fire) begin
      v_d = 1'b1;
      i_d = fire_idx;
      b_d = fire_bytes;
    end else if (evt_ready) begin
      v_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      i_q <= '0;
      b_q <= '0;
    end else begin
      v_q <= v_d;
      i_q <= i_d;
      b_q <= b_d;
    end
  end

  assign evt_valid = v_q;
  assign evt_idx   = i_q;
  assign evt_bytes = b_q;
endmodule

// File: rtl/rxring_addr_gen.sv
module rxring_addr_gen
  import rxr_pkg::*;
#(
  parameter int NUM_BUF = 16,
  parameter int LEN_W   = 16,
  localparam int IDX_W = $clog2(NUM_BUF),
  localparam int CNT_W = $clog2(NUM_BUF + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_clear,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic              cfg_gpu,
  input  logic              cfg_last,
  input  logic              req_valid,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_gpu,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic              evt_valid,
  input  logic              evt_ready,
  output logic [IDX_W-1:0]  evt_idx,
  output logic [SIZE_W-1:0] evt_bytes
);
  // reset: asserted at once, released on the clock
  logic rs_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q  <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs_meta_q  <= 1'b1;
      rst_sync_n <= rs_meta_q;
    end
  end

  buf_ent_t          wr_ent, cur_ent;
  logic [IDX_W-1:0]  cur_idx;
  logic [CNT_W-1:0]  ring_cnt;
  logic              evt_free, acc, acc_err, close_fire;
  logic [ADDR_W-1:0] acc_addr;
  logic [SIZE_W-1:0] close_bytes;

  assign wr_ent = '{base: cfg_base, size: cfg_size, gpu: cfg_gpu};

  rxr_table #(.NUM_BUF(NUM_BUF)) u_table (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (cfg_we),
    .wr_idx (cfg_idx),
    .wr_ent (wr_ent),
    .rd_idx (cur_idx),
    .rd_ent (cur_ent)
  );

  rxr_cursor #(.NUM_BUF(NUM_BUF), .LEN_W(LEN_W)) u_cursor (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cfg_we      (cfg_we),
    .cfg_clear   (cfg_clear),
    .cfg_last    (cfg_last),
    .cfg_idx     (cfg_idx),
    .req_valid   (req_valid),
    .req_len     (req_len),
    .evt_free    (evt_free),
    .cur_ent     (cur_ent),
    .cur_idx     (cur_idx),
    .ring_cnt    (ring_cnt),
    .req_ready   (req_ready),
    .acc         (acc),
    .acc_err     (acc_err),
    .acc_addr    (acc_addr),
    .close_fire  (close_fire),
    .close_bytes (close_bytes)
  );

  rxr_evt #(.NUM_BUF(NUM_BUF)) u_evt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .fire       (close_fire),
    .fire_idx   (cur_idx),
    .fire_bytes (close_bytes),
    .evt_ready  (evt_ready),
    .evt_free   (evt_free),
    .evt_valid  (evt_valid),
    .evt_idx    (evt_idx),
    .evt_bytes  (evt_bytes)
  );

  // response register
  logic              rv_d, re_d, rg_d;
  logic [ADDR_W-1:0] ra_d;
  logic [IDX_W-1:0]  ri_d;

  always_comb begin
    rv_d = acc;
    re_d = acc ? acc_err : rsp_err;
    ra_d = (acc && !acc_err) ? acc_addr : rsp_addr;
    rg_d = (acc && !acc_err) ? cur_ent.gpu : rsp_gpu;
    ri_d = acc ? cur_idx : rsp_idx;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_addr  <= '0;
      rsp_gpu   <= 1'b0;
      rsp_idx   <= '0;
    end else begin
      rsp_valid <= rv_d;
      rsp_err   <= re_d;
      rsp_addr  <= ra_d;
      rsp_gpu   <= rg_d;
      rsp_idx   <= ri_d;
    end
  end
endmodule

// File: rtl/rxring_addr_gen_chk.sv
module rxring_addr_gen_chk #(
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 5,
  parameter int SIZE_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              cfg_clear,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              evt_valid,
  input logic              evt_ready,
  input logic [IDX_W-1:0]  evt_idx,
  input logic [SIZE_W-1:0] evt_bytes,
  input logic [CNT_W-1:0]  ring_cnt
);
  a_r8_evt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |=> evt_valid && $stable(evt_idx) && $stable(evt_bytes));

  a_r8_stall_on_held: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |-> !req_ready);

  a_r2_cfg_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we || cfg_clear) |-> !req_ready);

  a_r3_rsp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  a_r3_no_rsp_without_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready));

  a_r7_err_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (ring_cnt == '0) |=> rsp_err);

  a_r4_evt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_bytes != '0));
endmodule

bind rxring_addr_gen rxring_addr_gen_chk #(
  .IDX_W(IDX_W), .CNT_W(CNT_W), .SIZE_W(rxr_pkg::SIZE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cfg_we    (cfg_we),
  .cfg_clear (cfg_clear),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .evt_valid (evt_valid),
  .evt_ready (evt_ready),
  .evt_idx   (evt_idx),
  .evt_bytes (evt_bytes),
  .ring_cnt  (ring_cnt)
);

// File: tb/tb_rxring_addr_gen.sv
module tb_rxring_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_clear = 1'b0, cfg_gpu = 1'b0, cfg_last = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [63:0] cfg_base = '0;
  logic [31:0] cfg_size = '0;
  logic        req_valid = 1'b0, evt_ready = 1'b0;
  logic [15:0] req_len = '0;
  logic        req_ready, rsp_valid, rsp_err, rsp_gpu, evt_valid;
  logic [63:0] rsp_addr;
  logic [3:0]  rsp_idx, evt_idx;
  logic [31:0] evt_bytes;

  always #5 clk = ~clk;

  rxring_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_clear(cfg_clear),
    .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .cfg_gpu(cfg_gpu), .cfg_last(cfg_last), .req_valid(req_valid),
    .req_len(req_len), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_addr(rsp_addr), .rsp_gpu(rsp_gpu),
    .rsp_idx(rsp_idx), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_idx(evt_idx), .evt_bytes(evt_bytes)
  );

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  // reference model state
  logic [63:0] mbase [16];
  int unsigned msize [16];
  bit          mgpu  [16];
  int unsigned mcnt = 0, mcur = 0, moff = 0;
  bit          mev = 0;
  int unsigned mev_idx = 0, mev_bytes = 0, nclose = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one clock cycle, started just after a falling edge
  task automatic step(input bit v, input int unsigned len, input bit er,
                      input string tag, output bit acc);
    bit free, rdy, err, close;
    int unsigned cidx, cbytes, eidx, nl;
    logic [63:0] eaddr;
    bit egpu;
    nl = len & 32'hFFFF;
    req_valid = v; req_len = nl[15:0]; evt_ready = er;
    #1;
    free = !mev || er; rdy = 0; err = 0; close = 0;
    cidx = 0; cbytes = 0; eidx = mcur; eaddr = '0; egpu = 0;
    if (!free) rdy = 0;
    else if (mcnt == 0) begin rdy = 1; err = 1; end
    else if (nl == 0 || nl > msize[mcur]) begin rdy = 1; err = 1; end
    else if (moff + nl > msize[mcur]) begin
      rdy = 0; close = v; cidx = mcur; cbytes = moff;
    end else begin
      rdy = 1;
      eaddr = mbase[mcur] + 64'(moff); egpu = mgpu[mcur];
      if (v && (moff + nl == msize[mcur])) begin
        close = 1; cidx = mcur; cbytes = msize[mcur];
      end
    end
    acc = v && rdy;
    chk(req_ready == rdy, tag, "req_ready", 64'(req_ready), 64'(rdy));
    @(posedge clk); #1;
    if (acc && !err) moff += nl;
    if (close) begin
      mev = 1; mev_idx = cidx; mev_bytes = cbytes; nclose++;
      mcur = (mcur + 1 == mcnt) ? 0 : mcur + 1;
      moff = 0;
    end else if (mev && er) mev = 0;
    chk(rsp_valid == acc, tag, "rsp_valid", 64'(rsp_valid), 64'(acc));
    if (acc) begin
      chk(rsp_err == err, tag, "rsp_err", 64'(rsp_err), 64'(err));
      if (!err) begin
        chk(rsp_addr == eaddr, tag, "rsp_addr", rsp_addr, eaddr);
        chk(rsp_idx == 4'(eidx) && rsp_gpu == egpu, tag, "rsp_idx/gpu",
            {rsp_gpu, 4'(rsp_idx)}, {egpu, 4'(eidx)});
      end
    end
    chk(evt_valid == mev, tag, "evt_valid", 64'(evt_valid), 64'(mev));
    if (mev)
      chk(evt_idx == 4'(mev_idx) && evt_bytes == mev_bytes, tag, "evt idx/bytes",
          {evt_idx, evt_bytes}, {4'(mev_idx), 32'(mev_bytes)});
    req_valid = 0;
    @(negedge clk);
  endtask

  task automatic send(input int unsigned len, input bit er, input string tag);
    bit acc;
    acc = 0;
    for (int k = 0; k < 4 && !acc; k++) step(1, len, er, tag, acc);
  endtask

  task automatic cfg_write(input int unsigned idx, input logic [63:0] b,
                           input int unsigned sz, input bit g, input bit last);
    cfg_we = 1; cfg_idx = 4'(idx); cfg_base = b; cfg_size = sz; cfg_gpu = g;
    cfg_last = last; req_valid = 1; req_len = 16'd1; evt_ready = 0;
    #1;
    chk(req_ready == 1'b0, "R2", "req_ready during cfg", 64'(req_ready), 64'd0);
    @(posedge clk); #1;
    mbase[idx] = b; msize[idx] = sz; mgpu[idx] = g;
    if (last) begin mcnt = idx + 1; mcur = 0; moff = 0; end
    cfg_we = 0; cfg_last = 0; req_valid = 0;
    @(negedge clk);
  endtask

  task automatic cfg_clr();
    cfg_clear = 1; req_valid = 1; req_len = 16'd1; evt_ready = 0;
    #1;
    chk(req_ready == 1'b0, "R9", "req_ready during clear", 64'(req_ready), 64'd0);
    @(posedge clk); #1;
    mcnt = 0; mcur = 0; moff = 0;
    cfg_clear = 0; req_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    bit a;
    int unsigned base_n;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    #1;
    chk(rsp_valid == 0 && evt_valid == 0, "R1", "outputs after reset",
        {rsp_valid, evt_valid}, 64'd0);
    chk(req_ready == 1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);
    @(negedge clk);
    step(1, 64, 1, "R1", a);   // no ring yet: error answer
    step(1, 64, 1, "R7", a);

    // R2/R3: four-entry ring, mixed memory types
    cfg_write(0, 64'h0000_1000_0000_0000, 256, 0, 0);
    cfg_write(1, 64'h0000_2000_0000_0100, 256, 1, 0);
    cfg_write(2, 64'h0000_3000_0000_0200, 128, 0, 0);
    cfg_write(3, 64'h0000_4000_0000_0300, 512, 1, 1);
    send(40, 1, "R3");
    send(100, 1, "R3");
    send(16, 1, "R3");
    // R5: 156 used of 256, 120 does not fit -> close with 156, go to entry 1
    send(120, 1, "R5");
    chk(rsp_idx == 4'd1 && rsp_addr == 64'h0000_2000_0000_0100, "R5",
        "spilled packet placement", rsp_addr, 64'h0000_2000_0000_0100);
    // R4: fill entry 1 exactly
    send(136, 1, "R4");
    // R7: zero length and too large for entry 2
    send(0, 1, "R7");
    send(200, 1, "R7");
    send(32, 1, "R7");
    chk(rsp_addr == 64'h0000_3000_0000_0200, "R7", "offset unchanged by errors",
        rsp_addr, 64'h0000_3000_0000_0200);
    // R8: fill entry 2 and hold the event
    send(96, 0, "R8");
    for (int k = 0; k < 3; k++) step(1, 64, 0, "R8", a);
    step(1, 64, 1, "R8", a);
    // R6: fill entry 3, then wrap to entry 0
    send(448, 1, "R6");
    send(8, 1, "R6");
    chk(rsp_idx == 4'd0 && rsp_addr == 64'h0000_1000_0000_0000, "R6",
        "wrap to entry 0", rsp_addr, 64'h0000_1000_0000_0000);

    // R4: 4 buffers of 8 payloads, 32 packets -> 4 events, back at entry 0
    for (int i = 0; i < 4; i++)
      cfg_write(i, 64'h8000_0000_0000_0000 + 64'(i) * 64'h10_0000, 8 * 184, 1, i == 3);
    nclose = 0;
    for (int i = 0; i < 32; i++) send(184, 1, "R4");
    chk(nclose == 4, "R4", "event count for 32 packets", 64'(nclose), 64'd4);
    send(184, 1, "R6");
    chk(rsp_idx == 4'd0 && rsp_addr == 64'h8000_0000_0000_0000, "R6",
        "wrap after burst", rsp_addr, 64'h8000_0000_0000_0000);

    // random phase
    for (int i = 0; i < 6; i++)
      cfg_write(i, {$urandom, $urandom}, 200 + ($urandom % 400), 1'($urandom), i == 5);
    for (int i = 0; i < 4000; i++) begin
      int unsigned r, len;
      r = $urandom % 20;
      len = (r == 0) ? 0 : (r == 1) ? 1000 : 1 + ($urandom % 300);
      step(($urandom % 4) != 0, len, 1'($urandom), "R3", a);
    end
    base_n = nchk;
    // drain any held event
    step(0, 1, 1, "R8", a);

    // R9: clear deregisters the ring
    cfg_clr();
    step(1, 64, 1, "R9", a);
    chk(rsp_err == 1, "R9", "error after clear", 64'(rsp_err), 64'd1);
    chk(nchk > base_n, "R9", "checks ran", 64'(nchk), 64'(base_n));

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule